// File: doc/BRIEF.md
# Task Switch Permission Checker

This block decides whether a requested hardware task switch may go ahead. The caller presents one request. The request carries the cause of the switch, three privilege levels and three fields of the target descriptor: the present flag, the segment limit and the busy flag. The block answers with a single permit flag. When it refuses, it also gives a one-hot fault cause.

The decision logic is purely combinational. A thin wrapper registers the request so that the answer appears one cycle after the request is offered. This lets the checker sit between pipeline stages without lengthening the path that feeds it. Setting the parameter `REG_IN` to 0 removes the wrapper and gives a same-cycle answer.

The block only decides whether the switch is allowed. It does not touch memory, does not check paging, and does not save or load any task state.

Top module: `tsw_gate`

## Requirements
- R1: `cause_i` is encoded as 0 jump, 1 call, 2 return-from-interrupt, 3 software interrupt, 4 hardware interrupt and 5 exception. Codes 6 and 7 always raise a privilege fault.
- R2: For jump, call and software interrupt, both `cpl_i <= dpl_i` and `rpl_i <= dpl_i` (unsigned) must hold. Otherwise a privilege fault is raised.
- R3: Return-from-interrupt, hardware interrupt and exception never raise a privilege fault, whatever the three privilege levels are.
- R4: A target with `present_i` = 0 raises a not-present fault.
- R5: A target with `limit_i` below 0x67 raises a limit fault. A limit of exactly 0x67 is accepted.
- R6: For every cause other than return-from-interrupt, a target with `busy_i` = 1 raises a busy fault.
- R7: For return-from-interrupt, a target with `busy_i` = 0 raises a busy fault.
- R8: `fault_o` is one-hot: bit 0 privilege, bit 1 not present, bit 2 limit, bit 3 busy. When several checks fail, only the first fault in that order is reported.
- R9: `permit_o` is 1 exactly when a valid answer carries no fault.
- R10: `valid_o` rises one clock after `req_valid_i` was sampled high. When `valid_o` is 0, both `permit_o` and `fault_o` are 0.
- R11: While `rst_ni` is low, `valid_o`, `permit_o` and `fault_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | A request is offered this cycle |
| cause_i | input | 3 | Cause of the switch (R1 encoding) |
| cpl_i | input | PL_W | Current privilege level |
| rpl_i | input | PL_W | Requestor privilege level of the target selector |
| dpl_i | input | PL_W | Privilege level of the referenced gate or descriptor |
| present_i | input | 1 | Target descriptor present flag |
| limit_i | input | LIMIT_W | Target descriptor segment limit |
| busy_i | input | 1 | Target descriptor busy flag |
| valid_o | output | 1 | An answer is presented |
| permit_o | output | 1 | The switch may proceed |
| fault_o | output | 4 | One-hot fault cause |

## Verification
The timing assertions assume the registered wrapper is in place (`REG_IN` = 1). They also assume that every cycle with `req_valid_i` high carries a fully defined request, so the cause, privilege and descriptor fields are never X. The bench offers one request at a time, driven on the falling edge, and holds every field at a known value. It drops `req_valid_i` between requests, so each answer can be tied to exactly one request and an idle cycle can be observed.

// File: rtl/tsw_pkg.sv
package tsw_pkg;
  localparam int CAUSE_W = 3;
  localparam int N_FAULT = 4;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_JMP   = 3'd0,
    CAUSE_CALL  = 3'd1,
    CAUSE_IRET  = 3'd2,
    CAUSE_SWINT = 3'd3,
    CAUSE_HWINT = 3'd4,
    CAUSE_EXC   = 3'd5
  } cause_e;

  // fault vector bit positions, also the priority order
  localparam int F_PRIV  = 0;
  localparam int F_NP    = 1;
  localparam int F_LIMIT = 2;
  localparam int F_BUSY  = 3;
endpackage

// File: rtl/tsw_priv_check.sv
module tsw_priv_check
  import tsw_pkg::*;
#(
  parameter int PL_W = 2
) (
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [PL_W-1:0]    cpl_i,
  input  logic [PL_W-1:0]    rpl_i,
  input  logic [PL_W-1:0]    dpl_i,
  output logic               priv_fault_o
);
  logic lvl_ok;
  assign lvl_ok = (cpl_i <= dpl_i) && (rpl_i <= dpl_i);

  always_comb begin
    unique case (cause_i)
      CAUSE_JMP, CAUSE_CALL, CAUSE_SWINT: priv_fault_o = ~lvl_ok;
      CAUSE_IRET, CAUSE_HWINT, CAUSE_EXC:  priv_fault_o = 1'b0;
      default:                             priv_fault_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/tsw_desc_check.sv
module tsw_desc_check
  import tsw_pkg::*;
#(
  parameter int          LIMIT_W   = 20,
  parameter int unsigned MIN_LIMIT = 32'h67
) (
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic               present_i,
  input  logic [LIMIT_W-1:0] limit_i,
  input  logic               busy_i,
  output logic               np_fault_o,
  output logic               limit_fault_o,
  output logic               busy_fault_o
);
  localparam logic [LIMIT_W-1:0] MinLim = LIMIT_W'(MIN_LIMIT);

  logic want_busy;
  assign want_busy     = (cause_i == CAUSE_IRET);
  assign np_fault_o    = ~present_i;
  assign limit_fault_o = (limit_i < MinLim);
  assign busy_fault_o  = (busy_i != want_busy);
endmodule

// File: rtl/tsw_fault_arb.sv
module tsw_fault_arb #(
  parameter int N = 4
) (
  input  logic [N-1:0] raw_i,
  output logic [N-1:0] fault_o,
  output logic         permit_o
);
  for (genvar i = 0; i < N; i++) begin : g_pri
    if (i == 0) begin : g_top
      assign fault_o[i] = raw_i[i];
    end else begin : g_low
      assign fault_o[i] = raw_i[i] & ~(|raw_i[i-1:0]);
    end
  end
  assign permit_o = ~(|raw_i);
endmodule

// File: rtl/tsw_gate.sv
module tsw_gate
  import tsw_pkg::*;
#(
  parameter int          PL_W      = 2,
  parameter int          LIMIT_W   = 20,
  parameter int unsigned MIN_LIMIT = 32'h67,
  parameter bit          REG_IN    = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [2:0]         cause_i,
  input  logic [PL_W-1:0]    cpl_i,
  input  logic [PL_W-1:0]    rpl_i,
  input  logic [PL_W-1:0]    dpl_i,
  input  logic               present_i,
  input  logic [LIMIT_W-1:0] limit_i,
  input  logic               busy_i,
  output logic               valid_o,
  output logic               permit_o,
  output logic [3:0]         fault_o
);
  logic               v_q;
  logic [CAUSE_W-1:0] cause_q;
  logic [PL_W-1:0]    cpl_q, rpl_q, dpl_q;
  logic               present_q, busy_q;
  logic [LIMIT_W-1:0] limit_q;

  if (REG_IN) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q       <= 1'b0;
        cause_q   <= '0;
        cpl_q     <= '0;
        rpl_q     <= '0;
        dpl_q     <= '0;
        present_q <= 1'b0;
        limit_q   <= '0;
        busy_q    <= 1'b0;
      end else begin
        v_q <= req_valid_i;
        if (req_valid_i) begin
          cause_q   <= cause_i;
          cpl_q     <= cpl_i;
          rpl_q     <= rpl_i;
          dpl_q     <= dpl_i;
          present_q <= present_i;
          limit_q   <= limit_i;
          busy_q    <= busy_i;
        end
      end
    end
  end else begin : g_comb
    assign v_q       = req_valid_i & rst_ni;
    assign cause_q   = cause_i;
    assign cpl_q     = cpl_i;
    assign rpl_q     = rpl_i;
    assign dpl_q     = dpl_i;
    assign present_q = present_i;
    assign limit_q   = limit_i;
    assign busy_q    = busy_i;
    logic unused_clk;
    assign unused_clk = clk_i;
  end

  logic [N_FAULT-1:0] raw, fault;
  logic               ok;

  tsw_priv_check #(.PL_W(PL_W)) i_priv (
    .cause_i      (cause_q),
    .cpl_i        (cpl_q),
    .rpl_i        (rpl_q),
    .dpl_i        (dpl_q),
    .priv_fault_o (raw[F_PRIV])
  );

  tsw_desc_check #(.LIMIT_W(LIMIT_W), .MIN_LIMIT(MIN_LIMIT)) i_desc (
    .cause_i       (cause_q),
    .present_i     (present_q),
    .limit_i       (limit_q),
    .busy_i        (busy_q),
    .np_fault_o    (raw[F_NP]),
    .limit_fault_o (raw[F_LIMIT]),
    .busy_fault_o  (raw[F_BUSY])
  );

  tsw_fault_arb #(.N(N_FAULT)) i_arb (
    .raw_i    (raw),
    .fault_o  (fault),
    .permit_o (ok)
  );

  assign valid_o  = v_q;
  assign permit_o = v_q & ok;
  assign fault_o  = v_q ? fault : '0;
endmodule

// File: rtl/tsw_gate_chk.sv
module tsw_gate_chk #(
  parameter int          PL_W      = 2,
  parameter int          LIMIT_W   = 20,
  parameter int unsigned MIN_LIMIT = 32'h67,
  parameter bit          REG_IN    = 1'b1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_valid_i,
  input logic [2:0]         cause_i,
  input logic [PL_W-1:0]    cpl_i,
  input logic [PL_W-1:0]    rpl_i,
  input logic [PL_W-1:0]    dpl_i,
  input logic               present_i,
  input logic [LIMIT_W-1:0] limit_i,
  input logic               busy_i,
  input logic               valid_o,
  input logic               permit_o,
  input logic [3:0]         fault_o
);
  localparam logic [LIMIT_W-1:0] MinLim = LIMIT_W'(MIN_LIMIT);

  assert_onehot_fault_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(fault_o));

  assert_permit_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (permit_o != (|fault_o)));

  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (!permit_o && fault_o == 4'b0000));

  if (REG_IN) begin : g_seq
    assert_latency_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_valid_i |=> valid_o);

    assert_priv_jmp_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && cause_i == 3'd0 && (cpl_i > dpl_i || rpl_i > dpl_i))
      |=> fault_o == 4'b0001);

    assert_unused_cause_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && cause_i > 3'd5) |=> fault_o == 4'b0001);

    assert_not_present_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && !present_i) |=> !permit_o);

    assert_short_limit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && limit_i < MinLim) |=> !permit_o);

    assert_iret_exempt_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && cause_i == 3'd2 && present_i && limit_i >= MinLim && busy_i)
      |=> permit_o);

    assert_iret_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && cause_i == 3'd2 && !busy_i) |=> !permit_o);
  end
endmodule

bind tsw_gate tsw_gate_chk #(
  .PL_W(PL_W), .LIMIT_W(LIMIT_W), .MIN_LIMIT(MIN_LIMIT), .REG_IN(REG_IN)
) i_tsw_gate_chk (.*);

// File: tb/test_tsw_gate.sv
module test_tsw_gate;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 20000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [2:0]  cause_i = '0;
  logic [1:0]  cpl_i = '0, rpl_i = '0, dpl_i = '0;
  logic        present_i = 1'b0;
  logic [19:0] limit_i = '0;
  logic        busy_i = 1'b0;
  logic        valid_o, permit_o;
  logic [3:0]  fault_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  tsw_gate i_tsw_gate (.*);

  task automatic check(input string req, input logic exp_valid,
                       input logic exp_permit, input logic [3:0] exp_fault);
    checks++;
    if (valid_o !== exp_valid || permit_o !== exp_permit || fault_o !== exp_fault) begin
      errors++;
      $display("FAIL %s: valid=%b permit=%b fault=%b, expected valid=%b permit=%b fault=%b",
               req, valid_o, permit_o, fault_o, exp_valid, exp_permit, exp_fault);
    end
  endtask

  // one request; answer registered at the following posedge, sampled at the next negedge
  task automatic offer(input logic [2:0] c, input logic [1:0] cpl, input logic [1:0] rpl,
                       input logic [1:0] dpl, input logic p, input logic [19:0] lim,
                       input logic b);
    @(negedge clk_i);
    cause_i = c; cpl_i = cpl; rpl_i = rpl; dpl_i = dpl;
    present_i = p; limit_i = lim; busy_i = b; req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  task automatic t_reset;
    #(CLK_PERIOD*2);
    check("R11 reset", 1'b0, 1'b0, 4'b0000);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    check("R11 after release", 1'b0, 1'b0, 4'b0000);
  endtask

  task automatic t_jmp_call_priv;
    offer(3'd0, 2'd0, 2'd0, 2'd0, 1'b1, 20'h67, 1'b0);
    check("R2 jmp equal levels", 1'b1, 1'b1, 4'b0000);
    offer(3'd0, 2'd3, 2'd0, 2'd2, 1'b1, 20'h100, 1'b0);
    check("R2 jmp cpl above dpl", 1'b1, 1'b0, 4'b0001);
    offer(3'd1, 2'd0, 2'd3, 2'd2, 1'b1, 20'h100, 1'b0);
    check("R2 call rpl above dpl", 1'b1, 1'b0, 4'b0001);
    offer(3'd1, 2'd2, 2'd2, 2'd2, 1'b1, 20'h100, 1'b0);
    check("R2 call at dpl", 1'b1, 1'b1, 4'b0000);
  endtask

  task automatic t_swint_priv;
    offer(3'd3, 2'd3, 2'd0, 2'd0, 1'b1, 20'h100, 1'b0);
    check("R2 swint cpl above dpl", 1'b1, 1'b0, 4'b0001);
    offer(3'd3, 2'd0, 2'd0, 2'd3, 1'b1, 20'h100, 1'b0);
    check("R2 swint allowed", 1'b1, 1'b1, 4'b0000);
  endtask

  task automatic t_exempt;
    offer(3'd4, 2'd3, 2'd3, 2'd0, 1'b1, 20'h100, 1'b0);
    check("R3 hwint exempt", 1'b1, 1'b1, 4'b0000);
    offer(3'd5, 2'd3, 2'd3, 2'd0, 1'b1, 20'h100, 1'b0);
    check("R3 exception exempt", 1'b1, 1'b1, 4'b0000);
    offer(3'd2, 2'd3, 2'd3, 2'd0, 1'b1, 20'h100, 1'b1);
    check("R3 iret exempt", 1'b1, 1'b1, 4'b0000);
  endtask

  task automatic t_present;
    offer(3'd0, 2'd0, 2'd0, 2'd0, 1'b0, 20'h100, 1'b0);
    check("R4 not present", 1'b1, 1'b0, 4'b0010);
  endtask

  task automatic t_limit;
    offer(3'd1, 2'd0, 2'd0, 2'd0, 1'b1, 20'h66, 1'b0);
    check("R5 limit 0x66", 1'b1, 1'b0, 4'b0100);
    offer(3'd1, 2'd0, 2'd0, 2'd0, 1'b1, 20'hFFFFF, 1'b0);
    check("R5 limit max", 1'b1, 1'b1, 4'b0000);
  endtask

  task automatic t_busy;
    offer(3'd0, 2'd0, 2'd0, 2'd0, 1'b1, 20'h100, 1'b1);
    check("R6 jmp busy target", 1'b1, 1'b0, 4'b1000);
    offer(3'd5, 2'd0, 2'd0, 2'd0, 1'b1, 20'h100, 1'b1);
    check("R6 exception busy target", 1'b1, 1'b0, 4'b1000);
    offer(3'd2, 2'd0, 2'd0, 2'd0, 1'b1, 20'h100, 1'b0);
    check("R7 iret idle target", 1'b1, 1'b0, 4'b1000);
  endtask

  task automatic t_priority;
    offer(3'd0, 2'd3, 2'd0, 2'd0, 1'b0, 20'h0, 1'b1);
    check("R8 all fail -> priv", 1'b1, 1'b0, 4'b0001);
    offer(3'd0, 2'd0, 2'd0, 2'd0, 1'b0, 20'h0, 1'b1);
    check("R8 np over limit", 1'b1, 1'b0, 4'b0010);
    offer(3'd0, 2'd0, 2'd0, 2'd0, 1'b1, 20'h0, 1'b1);
    check("R8 limit over busy", 1'b1, 1'b0, 4'b0100);
  endtask

  task automatic t_unused;
    offer(3'd6, 2'd0, 2'd0, 2'd3, 1'b1, 20'h100, 1'b0);
    check("R1 code 6", 1'b1, 1'b0, 4'b0001);
    offer(3'd7, 2'd0, 2'd0, 2'd3, 1'b1, 20'h100, 1'b1);
    check("R1 code 7", 1'b1, 1'b0, 4'b0001);
  endtask

  task automatic t_idle;
    offer(3'd0, 2'd0, 2'd0, 2'd0, 1'b0, 20'h0, 1'b1);
    @(negedge clk_i);
    check("R10 idle after request", 1'b0, 1'b0, 4'b0000);
    check("R9 no permit when idle", 1'b0, 1'b0, 4'b0000);
  endtask

  initial begin
    t_reset();
    t_jmp_call_priv();
    t_swint_priv();
    t_exempt();
    t_present();
    t_limit();
    t_busy();
    t_priority();
    t_unused();
    t_idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule